// File: doc/BRIEF.md
# GPIO Bank with Edge-Triggered Interrupts

This block controls one bank of 32 general-purpose pins and sits behind a small 32-bit register bus. Software selects each pin's direction and reads the synchronized level of every pin. Output latches are never written directly: a write-one-to-set register raises chosen latches and a write-one-to-clear register lowers them. Because of this, one agent can change some pins without disturbing the others and without a read-modify-write.

Each pin has separate enables for rising edges and for falling edges. A qualifying edge latches the pin's bit in a status register. Software clears that register by writing ones to it. A single level interrupt stays high while any status bit is set. The block also holds a two-bit alternate-function code for each pin and drives all 64 code bits out to the pad-muxing logic.

Bus requests use a valid/ready pair. The block never applies back-pressure: `req_ready` is always high, and a request is accepted on any clock edge where `req_valid` is high. A read returns its data exactly one cycle after it is accepted, marked by `rsp_valid`. The response cannot be stalled, so the requester must always be able to accept it.

Top module: `gpio_edge_bank`

## Requirements
- R1: After reset, direction, output latches, both edge-enable registers, the status register, the alternate-function codes and `irq` are all 0.
- R2: A write to offset 0x08 sets every output latch whose data bit is 1 and leaves the other latches unchanged. `pin_out` shows the result on the cycle after the write. Reads of offset 0x08 return 0.
- R3: A write to offset 0x0C clears every output latch whose data bit is 1 and leaves the other latches unchanged. Reads of offset 0x0C return 0.
- R4: Offset 0x04 holds the direction register, which is writable and readable. Bit n = 1 makes pin n an output, and `pin_oe[n]` follows that bit.
- R5: Offset 0x00 is read-only. It returns each pin's level after a two-flop synchronizer, and writes to it have no effect.
- R6: When rise-enable bit n (offset 0x10) is 1, a low-to-high change of synchronized pin n sets status bit n. When the bit is 0, that change leaves status bit n unchanged.
- R7: When fall-enable bit n (offset 0x14) is 1, a high-to-low change of synchronized pin n sets status bit n.
- R8: A pin with both enables set latches its status bit on either edge.
- R9: Writing to offset 0x18 clears each status bit whose data bit is 1. Bits written with 0 keep their value.
- R10: If an edge on pin n is detected in the same cycle as a write that clears status bit n, the bit stays set.
- R11: `irq` is the registered OR of all status bits. It rises one cycle after a status bit sets and falls one cycle after the last set bit clears.
- R12: Pin n's alternate-function code sits at word 0x1C + 4*(n/16), bits 2*(n%16)+1 to 2*(n%16). The same code appears on `alt_sel[2n+1:2n]`.
- R13: `req_ready` is always 1. A read accepted at one edge produces `rsp_valid` with its data at the next edge. Writes produce no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 32 | Asynchronous pin levels from the pads |
| pin_out | output | 32 | Output latch values |
| pin_oe | output | 32 | Output enables (direction register) |
| alt_sel | output | 64 | Two-bit alternate-function code per pin |
| irq | output | 1 | Level interrupt, high while any status bit is set |
| req_valid | input | 1 | Bus request valid |
| req_ready | output | 1 | Bus request ready (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |

## Verification
The properties assume that bus inputs are held low while reset is asserted. They also assume that `req_addr`, `req_write` and `req_wdata` are known whenever `req_valid` is high. The bench changes every input on the falling clock edge. It holds `req_valid` high for exactly one cycle per access and keeps it low during reset. The same-cycle edge-and-clear case is built by counting the synchronizer and detector registers, so that the clear write lands on the edge where the status bit would set.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned REG_W   = 32;
  localparam int unsigned ADDR_W  = 8;
  localparam int unsigned ALT_W   = 2;
  localparam int unsigned ALT_PER = REG_W / ALT_W;

  localparam logic [ADDR_W-1:0] OFF_LEVEL = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_DIR   = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_SET   = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_CLR   = 8'h0C;
  localparam logic [ADDR_W-1:0] OFF_RISE  = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_FALL  = 8'h14;
  localparam logic [ADDR_W-1:0] OFF_STAT  = 8'h18;
  localparam logic [ADDR_W-1:0] OFF_ALT0  = 8'h1C;
  localparam logic [ADDR_W-1:0] OFF_ALT1  = 8'h20;

  typedef struct packed {
    logic              wr;
    logic [ADDR_W-1:0] addr;
    logic [REG_W-1:0]  data;
  } wr_cmd_t;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= '0;
        else if (s == 0) chain[s] <= d;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_ctrl_regs.sv
module gpio_ctrl_regs
  import gpio_bank_pkg::*;
#(
  parameter int unsigned ALT_WORDS = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  wr_cmd_t                      cmd,
  output logic [REG_W-1:0]             dir_q,
  output logic [REG_W-1:0]             out_q,
  output logic [REG_W-1:0]             rise_q,
  output logic [REG_W-1:0]             fall_q,
  output logic [ALT_WORDS*REG_W-1:0]   alt_q,
  output logic [REG_W-1:0]             stat_clr
);
  localparam logic [ADDR_W-1:0] ALT_STEP = ADDR_W'(REG_W / 8);

  logic hit_dir, hit_set, hit_clr, hit_rise, hit_fall;

  assign hit_dir  = cmd.wr && (cmd.addr == OFF_DIR);
  assign hit_set  = cmd.wr && (cmd.addr == OFF_SET);
  assign hit_clr  = cmd.wr && (cmd.addr == OFF_CLR);
  assign hit_rise = cmd.wr && (cmd.addr == OFF_RISE);
  assign hit_fall = cmd.wr && (cmd.addr == OFF_FALL);
  assign stat_clr = (cmd.wr && (cmd.addr == OFF_STAT)) ? cmd.data : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      out_q  <= '0;
      rise_q <= '0;
      fall_q <= '0;
    end else begin
      if (hit_dir)  dir_q  <= cmd.data;
      if (hit_rise) rise_q <= cmd.data;
      if (hit_fall) fall_q <= cmd.data;
      if (hit_set)      out_q <= out_q | cmd.data;
      else if (hit_clr) out_q <= out_q & ~cmd.data;
    end
  end

  genvar w;
  generate
    for (w = 0; w < ALT_WORDS; w++) begin : g_alt
      localparam logic [ADDR_W-1:0] MY_OFF = OFF_ALT0 + ADDR_W'(w) * ALT_STEP;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) alt_q[w*REG_W +: REG_W] <= '0;
        else if (cmd.wr && (cmd.addr == MY_OFF))
          alt_q[w*REG_W +: REG_W] <= cmd.data;
      end
    end
  endgenerate
endmodule

// File: rtl/gpio_edge_unit.sv
module gpio_edge_unit
  import gpio_bank_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] lvl,
  input  logic [REG_W-1:0] rise_en,
  input  logic [REG_W-1:0] fall_en,
  input  logic [REG_W-1:0] clr_mask,
  output logic [REG_W-1:0] status_q,
  output logic [REG_W-1:0] events
);
  logic [REG_W-1:0] lvl_prev;

  always_comb begin
    events = (lvl & ~lvl_prev & rise_en) | (~lvl & lvl_prev & fall_en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_prev <= '0;
      status_q <= '0;
    end else begin
      lvl_prev <= lvl;
      // a new edge wins over a simultaneous clear
      status_q <= (status_q & ~clr_mask) | events;
    end
  end
endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [REG_W-1:0]         pin_in,
  output logic [REG_W-1:0]         pin_out,
  output logic [REG_W-1:0]         pin_oe,
  output logic [ALT_W*REG_W-1:0]   alt_sel,
  output logic                     irq,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_write,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [REG_W-1:0]         req_wdata,
  output logic                     rsp_valid,
  output logic [REG_W-1:0]         rsp_rdata
);
  localparam int unsigned ALT_WORDS = ALT_W;

  wr_cmd_t          cmd;
  logic [REG_W-1:0] lvl_sync, dir_q, out_q, rise_q, fall_q, stat_clr;
  logic [REG_W-1:0] status_q, events;
  logic [ALT_WORDS*REG_W-1:0] alt_q;
  logic [REG_W-1:0] rd_mux;
  logic             rd_fire;

  assign req_ready = 1'b1;
  assign cmd.wr    = req_valid && req_ready && req_write;
  assign cmd.addr  = req_addr;
  assign cmd.data  = req_wdata;
  assign rd_fire   = req_valid && req_ready && !req_write;

  gpio_sync #(.W(REG_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(lvl_sync)
  );

  gpio_ctrl_regs #(.ALT_WORDS(ALT_WORDS)) u_regs (
    .clk(clk), .rst_n(rst_n), .cmd(cmd),
    .dir_q(dir_q), .out_q(out_q), .rise_q(rise_q), .fall_q(fall_q),
    .alt_q(alt_q), .stat_clr(stat_clr)
  );

  gpio_edge_unit u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(lvl_sync),
    .rise_en(rise_q), .fall_en(fall_q), .clr_mask(stat_clr),
    .status_q(status_q), .events(events)
  );

  always_comb begin
    case (req_addr)
      OFF_LEVEL: rd_mux = lvl_sync;
      OFF_DIR:   rd_mux = dir_q;
      OFF_RISE:  rd_mux = rise_q;
      OFF_FALL:  rd_mux = fall_q;
      OFF_STAT:  rd_mux = status_q;
      OFF_ALT0:  rd_mux = alt_q[0 +: REG_W];
      OFF_ALT1:  rd_mux = alt_q[REG_W +: REG_W];
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      rsp_valid <= rd_fire;
      if (rd_fire) rsp_rdata <= rd_mux;
      irq <= |status_q;
    end
  end

  assign pin_out = out_q;
  assign pin_oe  = dir_q;
  assign alt_sel = alt_q;
endmodule

// File: rtl/gpio_edge_bank_chk.sv
module gpio_edge_bank_chk
  import gpio_bank_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [REG_W-1:0]  req_wdata,
  input logic              rsp_valid,
  input logic [REG_W-1:0]  pin_out,
  input logic [REG_W-1:0]  pin_oe,
  input logic [REG_W-1:0]  status_q,
  input logic              irq
);
  logic wr_set, wr_clr, wr_dir, wr_stat;
  assign wr_set  = req_valid && req_write && (req_addr == OFF_SET);
  assign wr_clr  = req_valid && req_write && (req_addr == OFF_CLR);
  assign wr_dir  = req_valid && req_write && (req_addr == OFF_DIR);
  assign wr_stat = req_valid && req_write && (req_addr == OFF_STAT);

  // R2
  set_bits_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> ((pin_out & $past(req_wdata)) == $past(req_wdata)));

  // R3
  clr_bits_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> ((pin_out & $past(req_wdata)) == '0));

  // R4
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_dir |=> $stable(pin_oe));

  // R9
  status_drop_needs_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q & ~$past(status_q)) != '0 || $stable(status_q) || $past(wr_stat))
    || (($past(status_q) & ~status_q) == '0));

  // R11
  irq_tracks_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ##1 (irq == $past(|status_q)));

  // R13
  rsp_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && !req_write));
endmodule

bind gpio_edge_bank gpio_edge_bank_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
  .pin_out(pin_out), .pin_oe(pin_oe), .status_q(status_q), .irq(irq)
);

// File: tb/gpio_edge_bank_tb.sv
module gpio_edge_bank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out, pin_oe;
  logic [63:0] alt_sel;
  logic        irq, req_ready, rsp_valid;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0, rsp_rdata;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  gpio_edge_bank u_dut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .alt_sel(alt_sel), .irq(irq), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    check("R13 rsp_valid", {63'd0, rsp_valid}, 64'd1);
    d = rsp_rdata;
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R1 pin_out", {32'd0, pin_out}, 0);
    check("R1 pin_oe", {32'd0, pin_oe}, 0);
    check("R1 alt_sel", alt_sel, 0);
    check("R1 irq", {63'd0, irq}, 0);
    check("R13 ready", {63'd0, req_ready}, 1);
    rd(8'h10, d); check("R1 rise", {32'd0, d}, 0);
    rd(8'h14, d); check("R1 fall", {32'd0, d}, 0);
    rd(8'h18, d); check("R1 status", {32'd0, d}, 0);
  endtask

  task automatic t_set_clr;
    logic [31:0] d;
    wr(8'h08, 32'hF0F0_0001);
    check("R2 set", {32'd0, pin_out}, 64'hF0F0_0001);
    wr(8'h08, 32'h0000_0100);
    check("R2 set keeps others", {32'd0, pin_out}, 64'hF0F0_0101);
    wr(8'h0C, 32'hF000_0001);
    check("R3 clear", {32'd0, pin_out}, 64'h00F0_0100);
    rd(8'h08, d); check("R2 set reads 0", {32'd0, d}, 0);
    rd(8'h0C, d); check("R3 clr reads 0", {32'd0, d}, 0);
  endtask

  task automatic t_dir;
    logic [31:0] d;
    wr(8'h04, 32'hA5A5_0F0F);
    check("R4 pin_oe", {32'd0, pin_oe}, 64'hA5A5_0F0F);
    rd(8'h04, d); check("R4 readback", {32'd0, d}, 64'hA5A5_0F0F);
    wr(8'h04, 32'h0);
  endtask

  task automatic t_level;
    logic [31:0] d;
    @(negedge clk); pin_in = 32'h1234_5678;
    wait_cyc(3);
    rd(8'h00, d); check("R5 level", {32'd0, d}, 64'h1234_5678);
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, d); check("R5 level write ignored", {32'd0, d}, 64'h1234_5678);
    @(negedge clk); pin_in = '0;
    wait_cyc(4);
  endtask

  task automatic t_edges;
    logic [31:0] d;
    wr(8'h10, 32'h0000_0005);   // rise: pins 0,2
    wr(8'h14, 32'h0000_0006);   // fall: pins 1,2
    @(negedge clk); pin_in = 32'h0000_000F;
    wait_cyc(4);
    rd(8'h18, d); check("R6 rise latch", {32'd0, d}, 64'h5);
    @(negedge clk); pin_in = 32'h0;
    wait_cyc(4);
    rd(8'h18, d); check("R7/R8 fall latch", {32'd0, d}, 64'h7);
    wr(8'h18, 32'h0000_0002);
    rd(8'h18, d); check("R9 w1c partial", {32'd0, d}, 64'h5);
    wr(8'h18, 32'h0);
    rd(8'h18, d); check("R9 zero write no effect", {32'd0, d}, 64'h5);
    wr(8'h18, 32'hFFFF_FFFF);
    rd(8'h18, d); check("R9 clear all", {32'd0, d}, 0);
  endtask

  task automatic t_irq;
    logic [31:0] d;
    @(negedge clk);
    check("R11 irq low", {63'd0, irq}, 0);
    pin_in = 32'h1;           // rise enabled on pin 0
    @(posedge clk);           // sync stage 1
    @(posedge clk);           // sync stage 2
    @(posedge clk);           // status sets
    @(negedge clk);
    check("R11 irq one cycle later", {63'd0, irq}, 0);
    @(negedge clk);
    check("R11 irq high", {63'd0, irq}, 1);
    wr(8'h18, 32'h1);
    check("R11 irq clears next cycle", {63'd0, irq}, 1);
    @(negedge clk);
    check("R11 irq low after clear", {63'd0, irq}, 0);
    @(negedge clk); pin_in = 32'h0;
    wait_cyc(4);
  endtask

  task automatic t_clear_race;
    logic [31:0] d;
    @(negedge clk); pin_in = 32'h1;
    wait_cyc(4);
    rd(8'h18, d); check("R6 pre race", {32'd0, d}, 64'h1);
    @(negedge clk); pin_in = 32'h0;
    wait_cyc(4);
    @(negedge clk); pin_in = 32'h1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = 8'h18; req_wdata = 32'h1;
    @(negedge clk);
    req_valid = 0; req_write = 0;
    rd(8'h18, d); check("R10 edge beats clear", {32'd0, d}, 64'h1);
    wr(8'h18, 32'hFFFF_FFFF);
    @(negedge clk); pin_in = 32'h0;
    wait_cyc(4);
    wr(8'h10, 32'h0);
    wr(8'h14, 32'h0);
    @(negedge clk); pin_in = 32'hFF;
    wait_cyc(4);
    rd(8'h18, d); check("R6 disabled edge ignored", {32'd0, d}, 0);
    pin_in = 32'h0; wait_cyc(4);
  endtask

  task automatic t_alt;
    logic [31:0] d;
    wr(8'h1C, 32'h0000_0036);    // pin1=01? bits[3:2]=01, pin2 bits[5:4]=11, pin0=10
    wr(8'h20, 32'h0000_000C);    // pin17 -> bits[3:2] = 11
    check("R12 pin0", {62'd0, alt_sel[1:0]}, 64'd2);
    check("R12 pin1", {62'd0, alt_sel[3:2]}, 64'd1);
    check("R12 pin2", {62'd0, alt_sel[5:4]}, 64'd3);
    check("R12 pin17", {62'd0, alt_sel[35:34]}, 64'd3);
    check("R12 pin16", {62'd0, alt_sel[33:32]}, 64'd0);
    rd(8'h20, d); check("R12 readback", {32'd0, d}, 64'hC);
  endtask

  initial begin
    wait_cyc(3);
    rst_n = 1;
    wait_cyc(2);
    t_reset();
    t_set_clr();
    t_dir();
    t_level();
    t_edges();
    t_irq();
    t_clear_race();
    t_alt();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule